// File: doc/BRIEF.md
# Instruction Window Address Translator

This block turns a logical instruction byte address into a physical memory address. The logical space is split into fixed 128 KB windows, and each window has one 16-bit mapping word. The upper bits of the logical address pick the window. The lower 17 bits are the byte offset inside it. The mapping word then chooses the target space and, for external unified memory, the segment number.

A request carries an address and a byte count. One clock later the block returns the following results, each held until the next request:

- the physical address;
- a target select;
- a fault flag;
- the byte count, trimmed so that the access stays inside its window.

One encoding is a test mode. It folds every offset into the first 2 KB of on-chip instruction memory and trims the count at each 2 KB boundary. The mapping words are loaded through a simple write port. At reset they take one of two start-up profiles, chosen by a configuration pin.

Top module: `iwin_xlate`

## Requirements
- R1: One cycle after `req_i` is sampled high, `vld_o` is high for exactly one cycle. `paddr_o`, `tgt_o`, `fault_o` and `len_o` change only on a clock edge where `req_i` is high, and hold their value otherwise. During reset the outputs are `vld_o=0`, `paddr_o=0`, `fault_o=0`, `len_o=0` and `tgt_o=2'b11`.
- R2: The window index is `laddr_i[18:17]` and the offset is `laddr_i[16:0]`. An index of 2 or 3 lies outside both windows. Such a request faults with `fault_o=1`, `len_o=0`, `paddr_o=0` and `tgt_o=2'b11`.
- R3: In a mapping word, bits 13:12 are the space code and bits 6:0 are the segment number. Bits 15:14 and 11:7 have no effect on the translation.
- R4: Space code 00 selects unified memory, shown as `tgt_o=2'b00`. The physical address is `(segment << 17) + offset`.
- R5: Space code 01 selects on-chip instruction memory, shown as `tgt_o=2'b01`. The physical address is `index * 0x20000 + offset`, and the segment number is ignored.
- R6: Space code 10 is reserved. A request that hits it faults exactly as in R2.
- R7: Space code 11 is the test mode. The result is `tgt_o=2'b01` with physical address `offset mod 0x800`. `len_o` is clipped so that the access ends at or before the next 0x800 boundary.
- R8: For space codes 00 and 01, `len_o = min(len_i, 0x20000 - offset)`.
- R9: With `hard_prof_i=0` during reset, both mapping words start at 0x1000. With `hard_prof_i=1` during reset, window 0 starts at 0x0000 and window 1 at 0x007F. Changing `hard_prof_i` outside reset has no effect.
- R10: When `map_we_i` is high at a clock edge, `map_wdata_i` is loaded into the word picked by `map_sel_i`. A request sampled at that same edge is translated with the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hard_prof_i | input | 1 | Selects the start-up profile of the mapping words while in reset |
| map_we_i | input | 1 | Mapping word write enable |
| map_sel_i | input | 1 | Mapping word to write |
| map_wdata_i | input | 16 | Mapping word write data |
| req_i | input | 1 | Translation request |
| laddr_i | input | 19 | Logical byte address |
| len_i | input | 8 | Requested byte count |
| vld_o | output | 1 | One-cycle pulse marking fresh results |
| paddr_o | output | 24 | Physical byte address |
| tgt_o | output | 2 | Target: 00 unified, 01 on-chip instruction, 11 none |
| fault_o | output | 1 | Request cannot be mapped |
| len_o | output | 8 | Byte count clipped to the boundary |

## Verification
The bench sweeps every space code in both windows. It uses offsets just inside the window end and on both sides of a 2 KB boundary, together with zero, small and maximum counts. A clipping subtractor that is off by one would show up at offset 0x1FFFF or 0x7F8. Folding the wrong bits in test mode, or shifting the segment by the wrong amount, would put wrong high bits on `paddr_o`. Letting stray mapping bits into the decode would send one of the junk-bit words to the wrong space.

Out-of-range windows and the reserved code must return a clean fault, not a half-formed address. The bench also writes a mapping word on the same edge as a request, to catch a write that bypasses into the translation early. Finally, it switches reset profiles and toggles the profile pin outside reset, to catch start-up values taken from the live pin.

// File: rtl/iwin_pkg.sv
`timescale 1ns/1ps
package iwin_pkg;
  typedef enum logic [1:0] {
    TGT_UNI  = 2'b00,
    TGT_IMEM = 2'b01,
    TGT_NONE = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    SP_UNI  = 2'b00,
    SP_IMEM = 2'b01,
    SP_RSVD = 2'b10,
    SP_TEST = 2'b11
  } space_e;

  localparam int unsigned SPACE_LSB = 12;
  localparam int unsigned SEG_W     = 7;
endpackage

// File: rtl/iwin_map_regs.sv
`timescale 1ns/1ps
module iwin_map_regs #(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned MAP_W   = 16,
  parameter int unsigned SEL_W   = 1,
  parameter logic [MAP_W-1:0] RST_SOFT  = 16'h1000,
  parameter logic [MAP_W-1:0] RST_HARD0 = 16'h0000,
  parameter logic [MAP_W-1:0] RST_HARD1 = 16'h007F
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            hard_prof_i,
  input  logic                            we_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [MAP_W-1:0]                wdata_i,
  output logic [NUM_WIN-1:0][MAP_W-1:0]   map_o
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_word
    localparam logic [MAP_W-1:0] HARD_V = (g == 0) ? RST_HARD0 : RST_HARD1;
    logic [MAP_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= hard_prof_i ? HARD_V : RST_SOFT;
      else if (we_i && (sel_i == SEL_W'(g)))      q <= wdata_i;
    end
    assign map_o[g] = q;
  end
endmodule

// File: rtl/iwin_decode.sv
`timescale 1ns/1ps
module iwin_decode
  import iwin_pkg::*;
#(
  parameter int unsigned WIN_BITS = 17,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned MAP_W    = 16,
  parameter int unsigned PA_W     = 24,
  parameter int unsigned TST_BITS = 11
) (
  input  logic                idx_ok_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [WIN_BITS-1:0] off_i,
  input  logic [MAP_W-1:0]    map_i,
  output logic [PA_W-1:0]     paddr_o,
  output tgt_e                tgt_o,
  output logic                fault_o,
  output logic                test_o,
  output logic [WIN_BITS-1:0] off_eff_o
);
  space_e           space;
  logic [SEG_W-1:0] seg;

  assign space = space_e'(map_i[SPACE_LSB +: 2]);
  assign seg   = map_i[SEG_W-1:0];

  always_comb begin
    paddr_o   = '0;
    tgt_o     = TGT_NONE;
    fault_o   = 1'b1;
    test_o    = 1'b0;
    off_eff_o = off_i;
    if (idx_ok_i) begin
      unique case (space)
        SP_UNI: begin
          paddr_o = PA_W'({seg, off_i});
          tgt_o   = TGT_UNI;
          fault_o = 1'b0;
        end
        SP_IMEM: begin
          paddr_o = PA_W'({idx_i, off_i});
          tgt_o   = TGT_IMEM;
          fault_o = 1'b0;
        end
        SP_TEST: begin
          off_eff_o = WIN_BITS'(off_i[TST_BITS-1:0]);
          paddr_o   = PA_W'(off_i[TST_BITS-1:0]);
          tgt_o     = TGT_IMEM;
          fault_o   = 1'b0;
          test_o    = 1'b1;
        end
        default: ;  // reserved space: fault
      endcase
    end
  end
endmodule

// File: rtl/iwin_len_clip.sv
`timescale 1ns/1ps
module iwin_len_clip #(
  parameter int unsigned WIN_BITS = 17,
  parameter int unsigned TST_BITS = 11,
  parameter int unsigned LEN_W    = 8
) (
  input  logic [LEN_W-1:0]    len_i,
  input  logic [WIN_BITS-1:0] off_i,
  input  logic                test_i,
  input  logic                fault_i,
  output logic [LEN_W-1:0]    len_o
);
  localparam logic [WIN_BITS:0] WIN_SZ = (WIN_BITS+1)'(1) << WIN_BITS;
  localparam logic [WIN_BITS:0] TST_SZ = (WIN_BITS+1)'(1) << TST_BITS;

  logic [WIN_BITS:0] rem;
  logic [WIN_BITS:0] len_x;

  always_comb begin
    if (test_i) rem = TST_SZ - (WIN_BITS+1)'(off_i[TST_BITS-1:0]);
    else        rem = WIN_SZ - (WIN_BITS+1)'(off_i);
    len_x = (WIN_BITS+1)'(len_i);
    if (fault_i)          len_o = '0;
    else if (len_x > rem) len_o = LEN_W'(rem);
    else                  len_o = len_i;
  end
endmodule

// File: rtl/iwin_xlate.sv
`timescale 1ns/1ps
module iwin_xlate
  import iwin_pkg::*;
#(
  parameter int unsigned WIN_BITS = 17,
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned LA_W     = 19,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned PA_W     = 24,
  parameter int unsigned MAP_W    = 16,
  parameter int unsigned TST_BITS = 11,
  parameter logic [MAP_W-1:0] RST_SOFT  = 16'h1000,
  parameter logic [MAP_W-1:0] RST_HARD0 = 16'h0000,
  parameter logic [MAP_W-1:0] RST_HARD1 = 16'h007F,
  localparam int unsigned SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hard_prof_i,
  input  logic              map_we_i,
  input  logic [SEL_W-1:0]  map_sel_i,
  input  logic [MAP_W-1:0]  map_wdata_i,
  input  logic              req_i,
  input  logic [LA_W-1:0]   laddr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              vld_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic [1:0]        tgt_o,
  output logic              fault_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int unsigned IDX_W = LA_W - WIN_BITS;

  logic [NUM_WIN-1:0][MAP_W-1:0] map_q;
  logic [IDX_W-1:0]    idx;
  logic [WIN_BITS-1:0] off;
  logic                idx_ok;
  logic [MAP_W-1:0]    map_sel;
  logic [PA_W-1:0]     pa_d;
  tgt_e                tgt_d;
  logic                fault_d;
  logic                test_d;
  logic [WIN_BITS-1:0] off_eff;
  logic [LEN_W-1:0]    len_d;

  iwin_map_regs #(
    .NUM_WIN(NUM_WIN), .MAP_W(MAP_W), .SEL_W(SEL_W),
    .RST_SOFT(RST_SOFT), .RST_HARD0(RST_HARD0), .RST_HARD1(RST_HARD1)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .hard_prof_i(hard_prof_i),
    .we_i(map_we_i), .sel_i(map_sel_i), .wdata_i(map_wdata_i),
    .map_o(map_q)
  );

  assign idx    = laddr_i[LA_W-1:WIN_BITS];
  assign off    = laddr_i[WIN_BITS-1:0];
  assign idx_ok = (32'(idx) < NUM_WIN);

  always_comb begin
    map_sel = '0;
    for (int k = 0; k < NUM_WIN; k++)
      if (idx == IDX_W'(k)) map_sel = map_q[k];
  end

  iwin_decode #(
    .WIN_BITS(WIN_BITS), .IDX_W(IDX_W), .MAP_W(MAP_W),
    .PA_W(PA_W), .TST_BITS(TST_BITS)
  ) u_dec (
    .idx_ok_i(idx_ok), .idx_i(idx), .off_i(off), .map_i(map_sel),
    .paddr_o(pa_d), .tgt_o(tgt_d), .fault_o(fault_d),
    .test_o(test_d), .off_eff_o(off_eff)
  );

  iwin_len_clip #(
    .WIN_BITS(WIN_BITS), .TST_BITS(TST_BITS), .LEN_W(LEN_W)
  ) u_clip (
    .len_i(len_i), .off_i(off_eff), .test_i(test_d),
    .fault_i(fault_d), .len_o(len_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      paddr_o <= '0;
      tgt_o   <= TGT_NONE;
      fault_o <= 1'b0;
      len_o   <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        paddr_o <= pa_d;
        tgt_o   <= tgt_d;
        fault_o <= fault_d;
        len_o   <= len_d;
      end
    end
  end
endmodule

// File: rtl/iwin_xlate_chk.sv
`timescale 1ns/1ps
module iwin_xlate_chk #(
  parameter int unsigned WIN_BITS = 17,
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned LA_W     = 19,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned PA_W     = 24,
  parameter int unsigned MAP_W    = 16,
  parameter int unsigned TST_BITS = 11
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic [LA_W-1:0]               laddr_i,
  input logic [LEN_W-1:0]              len_i,
  input logic                          vld_o,
  input logic [PA_W-1:0]               paddr_o,
  input logic [1:0]                    tgt_o,
  input logic                          fault_o,
  input logic [LEN_W-1:0]              len_o,
  input logic [NUM_WIN-1:0][MAP_W-1:0] map_i
);
  localparam int unsigned IDX_W = LA_W - WIN_BITS;
  localparam logic [WIN_BITS:0] WIN_SZ = (WIN_BITS+1)'(1) << WIN_BITS;
  localparam logic [WIN_BITS:0] TST_SZ = (WIN_BITS+1)'(1) << TST_BITS;

  logic [IDX_W-1:0]  idx;
  logic              in_rng;
  logic [1:0]        space;
  logic [WIN_BITS:0] end_pos;

  always_comb begin
    idx    = laddr_i[LA_W-1:WIN_BITS];
    in_rng = (32'(idx) < NUM_WIN);
    space  = 2'b00;
    for (int k = 0; k < NUM_WIN; k++)
      if (idx == IDX_W'(k)) space = map_i[k][13:12];
    end_pos = {1'b0, paddr_o[WIN_BITS-1:0]} + (WIN_BITS+1)'(len_o);
  end

  AST_VLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);  // R1
  AST_VLD_ONLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(req_i));  // R1
  AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable({paddr_o, tgt_o, fault_o, len_o}));  // R1
  AST_RANGE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !$past(in_rng) |-> fault_o);  // R2
  AST_RSVD_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && $past(in_rng && space == 2'b10) |-> fault_o);  // R6
  AST_FAULT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && fault_o |-> len_o == '0 && tgt_o == 2'b11 && paddr_o == '0);  // R6
  AST_TEST_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && $past(in_rng && space == 2'b11)
      |-> tgt_o == 2'b01 && (WIN_BITS+1)'(paddr_o) < TST_SZ && end_pos <= TST_SZ);  // R7
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> len_o <= $past(len_i));  // R8
  AST_NO_WIN_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !fault_o |-> end_pos <= WIN_SZ);  // R8
endmodule

bind iwin_xlate iwin_xlate_chk #(
  .WIN_BITS(WIN_BITS), .NUM_WIN(NUM_WIN), .LA_W(LA_W), .LEN_W(LEN_W),
  .PA_W(PA_W), .MAP_W(MAP_W), .TST_BITS(TST_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .laddr_i(laddr_i),
  .len_i(len_i), .vld_o(vld_o), .paddr_o(paddr_o), .tgt_o(tgt_o),
  .fault_o(fault_o), .len_o(len_o), .map_i(map_q)
);

// File: tb/iwin_xlate_tb_top.sv
`timescale 1ns/1ps
module iwin_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hard_prof_i = 1'b0;
  logic        map_we_i = 1'b0;
  logic        map_sel_i = 1'b0;
  logic [15:0] map_wdata_i = '0;
  logic        req_i = 1'b0;
  logic [18:0] laddr_i = '0;
  logic [7:0]  len_i = '0;
  logic        vld_o;
  logic [23:0] paddr_o;
  logic [1:0]  tgt_o;
  logic        fault_o;
  logic [7:0]  len_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] mapv [2];

  always #10 clk = ~clk;

  iwin_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hard_prof_i(hard_prof_i),
    .map_we_i(map_we_i), .map_sel_i(map_sel_i), .map_wdata_i(map_wdata_i),
    .req_i(req_i), .laddr_i(laddr_i), .len_i(len_i),
    .vld_o(vld_o), .paddr_o(paddr_o), .tgt_o(tgt_o),
    .fault_o(fault_o), .len_o(len_o)
  );

  task automatic chk(input bit ok, input string tag, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  function automatic void model(input logic [15:0] m, input logic [18:0] la,
                                input logic [7:0] ln, output logic [23:0] pa,
                                output logic [1:0] tg, output logic f,
                                output logic [7:0] lo);
    int idx = int'(la[18:17]);
    int off = int'(la[16:0]);
    int sp  = int'(m[13:12]);
    int rem = 0;
    pa = '0; tg = 2'b11; f = 1'b1; lo = '0;
    if (idx < 2 && sp != 2) begin
      f = 1'b0;
      if (sp == 0) begin
        pa = 24'(int'(m[6:0]) * 32'h20000 + off); tg = 2'b00; rem = 32'h20000 - off;
      end else if (sp == 1) begin
        pa = 24'(idx * 32'h20000 + off); tg = 2'b01; rem = 32'h20000 - off;
      end else begin
        pa = 24'(off % 32'h800); tg = 2'b01; rem = 32'h800 - (off % 32'h800);
      end
      lo = (int'(ln) > rem) ? 8'(rem) : ln;
    end
  endfunction

  task automatic wr_map(input int w, input logic [15:0] v);
    @(negedge clk);
    map_we_i = 1'b1; map_sel_i = w[0]; map_wdata_i = v;
    @(negedge clk);
    map_we_i = 1'b0;
    mapv[w] = v;
  endtask

  task automatic xlate(input logic [18:0] la, input logic [7:0] ln, input string tag);
    logic [23:0] pa; logic [1:0] tg; logic f; logic [7:0] lo;
    int w = int'(la[18:17]);
    model((w < 2) ? mapv[w] : 16'h0000, la, ln, pa, tg, f, lo);
    @(negedge clk);
    req_i = 1'b1; laddr_i = la; len_i = ln;
    @(negedge clk);
    req_i = 1'b0; laddr_i = ~la; len_i = ~ln;
    chk(vld_o === 1'b1 && paddr_o === pa && tgt_o === tg && fault_o === f && len_o === lo, tag,
        $sformatf("la=%h len=%h act vld=%b pa=%h tgt=%b f=%b len=%h exp vld=1 pa=%h tgt=%b f=%b len=%h",
                  la, ln, vld_o, paddr_o, tgt_o, fault_o, len_o, pa, tg, f, lo));
    @(negedge clk);
    chk(vld_o === 1'b0 && paddr_o === pa && tgt_o === tg && fault_o === f && len_o === lo, "R1",
        $sformatf("hold act vld=%b pa=%h tgt=%b f=%b len=%h exp vld=0 pa=%h tgt=%b f=%b len=%h",
                  vld_o, paddr_o, tgt_o, fault_o, len_o, pa, tg, f, lo));
  endtask

  initial begin
    logic [15:0] maps [8] = '{16'h0000, 16'h1000, 16'h2000, 16'h3000,
                              16'h0055, 16'h1055, 16'h3055, 16'hCF85};
    logic [16:0] offs [8] = '{17'h00000, 17'h00001, 17'h007FF, 17'h00800,
                              17'h007F8, 17'h1FFF0, 17'h1FFFF, 17'h12345};
    logic [7:0] lens [4] = '{8'h00, 8'h01, 8'h10, 8'hFF};
    string tags [4] = '{"R4 R8", "R5 R8", "R6", "R7"};

    // R9 soft profile
    mapv[0] = 16'h1000; mapv[1] = 16'h1000;
    repeat (3) @(negedge clk);
    chk(vld_o === 1'b0 && paddr_o === '0 && tgt_o === 2'b11 && fault_o === 1'b0 && len_o === '0,
        "R1", $sformatf("reset act vld=%b pa=%h tgt=%b f=%b len=%h exp 0 0 11 0 0",
                        vld_o, paddr_o, tgt_o, fault_o, len_o));
    rst_ni = 1'b1;
    xlate(19'h00040, 8'h08, "R9");
    xlate(19'h20040, 8'h08, "R9");

    // profile pin outside reset has no effect (R9)
    hard_prof_i = 1'b1;
    repeat (2) @(negedge clk);
    xlate(19'h20080, 8'h04, "R9");

    // R2 out-of-range windows
    xlate(19'h40000, 8'h10, "R2");
    xlate(19'h7FFFF, 8'hFF, "R2");

    // main sweep: R3 junk bits (0xCF85), R4..R8
    for (int mi = 0; mi < 8; mi++) begin
      for (int w = 0; w < 2; w++) begin
        wr_map(w, maps[mi]);
        for (int oi = 0; oi < 8; oi++)
          for (int li = 0; li < 4; li++)
            xlate({w[1:0], offs[oi]}, lens[li],
                  (mi == 7) ? "R3" : tags[int'(maps[mi][13:12])]);
      end
    end

    // R10: write and request on the same edge
    wr_map(0, 16'h1000);
    @(negedge clk);
    map_we_i = 1'b1; map_sel_i = 1'b0; map_wdata_i = 16'h0003;
    req_i = 1'b1; laddr_i = 19'h00100; len_i = 8'h02;
    @(negedge clk);
    map_we_i = 1'b0; req_i = 1'b0;
    chk(vld_o === 1'b1 && paddr_o === 24'h000100 && tgt_o === 2'b01, "R10",
        $sformatf("same-edge act pa=%h tgt=%b exp pa=000100 tgt=01", paddr_o, tgt_o));
    mapv[0] = 16'h0003;
    xlate(19'h00100, 8'h02, "R10");

    // R9 hard profile
    @(negedge clk);
    rst_ni = 1'b0; hard_prof_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1; hard_prof_i = 1'b0;
    mapv[0] = 16'h0000; mapv[1] = 16'h007F;
    xlate(19'h00040, 8'h08, "R9");
    xlate(19'h20040, 8'h08, "R9");
    chk(paddr_o === 24'hFE0040 && tgt_o === 2'b00, "R9",
        $sformatf("hard window1 act pa=%h tgt=%b exp pa=fe0040 tgt=00", paddr_o, tgt_o));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule